// File: doc/BRIEF.md
# Dual-channel serial ADC frame reader

This block is the master side of a link to a serial converter that samples two channels at the same instant. It makes the serial clock from the system clock with a programmable half-period divider and drives an active-low chip select. For each conversion it reads one fixed-length frame, most significant bit first, and splits the frame into two signed channel results. The converter changes its data line on the falling serial-clock edge, so the reader takes each bit on its own rising edge.

A host pulses `start_i` to begin. With `cont_i` low at that moment, exactly one frame is read. With `cont_i` high, frames follow back to back with chip select held low until a stop request. A stop request takes effect only at the next frame boundary. Both channel results, and a flag that reports a one in any position that should hold zero, are updated together with a one-cycle strobe.

Top module: `dual_adc_reader`

## Requirements
- R1: After synchronous reset, `cs_n_o` is 1, `sclk_o` is 1, `pair_valid_o` is 0 and `busy_o` is 0. Whenever chip select is released, the serial clock rests high.
- R2: While chip select is low, each frame takes exactly 32 rising edges of `sclk_o`.
- R3: Bits are taken on the rising edge of `sclk_o`. The first bit of a frame is its most significant bit.
- R4: Frame layout, first bit first: 2 zero bits, channel A (12 bits), 4 zero bits, channel B (12 bits), 2 zero bits. Both results are two's complement and appear on `ch_a_o` and `ch_b_o` as signed values. This includes -2048 and +2047.
- R5: After the last bit of a frame, `ch_a_o`, `ch_b_o` and `frame_err_o` change together and `pair_valid_o` is high for exactly one cycle.
- R6: In continuous mode (`cont_i` high when a start is accepted), each new frame begins on the next serial-clock period and `cs_n_o` stays low between frames.
- R7: A stop request (`stop_i` pulse at any time during a continuous run) ends the run after the frame in progress completes. `cs_n_o` only rises after a complete frame and stays high for at least two serial-clock phases before a new start is accepted.
- R8: If any of the 8 zero positions in the frame holds a one, `frame_err_o` is 1 with that frame's results, and the results are still delivered.
- R9: Each high and each low phase of `sclk_o` lasts `DIV_HALF` system clocks, with a minimum of one.
- R10: A start pulse while `busy_o` is high is ignored: no extra frame is read, and the mode of the run in progress does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken when idle |
| cont_i | input | 1 | Continuous mode select, sampled with start |
| stop_i | input | 1 | Stop request for a continuous run |
| sdo_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, rests high |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | High from accepted start to end of release gap |
| pair_valid_o | output | 1 | One-cycle strobe for a new result pair |
| ch_a_o | output | 12 | Channel A result, signed |
| ch_b_o | output | 12 | Channel B result, signed |
| frame_err_o | output | 1 | Nonzero bit found in a zero position |

## Verification
Two events can land on the same system cycle: the last rising serial-clock edge of a frame, which captures the final bit and decides whether to release chip select, and a stop request or a new start from the host. The bench sends a stop in the middle of the fourth continuous frame and checks that exactly four pairs arrive with a single chip-select release. It also holds `start_i` high across a whole run and checks that the start is taken only after the full release gap, and that start pulses sent during a frame add no frame.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_GAP
  } rd_state_e;
endpackage

// File: rtl/dadc_sclk_gen.sv
module dadc_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);

  logic [CW-1:0] cnt_q;

  // tick_o marks the last system clock of a serial-clock phase
  assign tick_o = run_i && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dadc_frame_ctrl.sv
module dadc_frame_ctrl
  import dadc_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic cont_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic run_o,
  output logic sample_o,
  output logic done_o,
  output logic sclk_o,
  output logic cs_n_o,
  output logic busy_o
);
  localparam int BCW = $clog2(FRAME_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

  rd_state_e      state_q;
  logic [BCW-1:0] bit_cnt_q;
  logic           cont_q;
  logic           stop_pend_q;
  logic           gap_half_q;

  assign run_o    = (state_q != ST_IDLE);
  assign busy_o   = (state_q != ST_IDLE);
  // rising serial-clock edge: capture the bit the slave set up on the fall
  assign sample_o = (state_q == ST_RUN) && tick_i && !sclk_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_IDLE;
      cs_n_o      <= 1'b1;
      sclk_o      <= 1'b1;
      bit_cnt_q   <= '0;
      cont_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      gap_half_q  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_RUN;
            cs_n_o      <= 1'b0;
            cont_q      <= cont_i;
            stop_pend_q <= 1'b0;
            bit_cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (tick_i) begin
            if (sclk_o) begin
              sclk_o <= 1'b0;
            end else begin
              sclk_o <= 1'b1;
              if (bit_cnt_q == LAST_BIT) begin
                bit_cnt_q <= '0;
                done_o    <= 1'b1;
                if (!cont_q || stop_pend_q || stop_i) state_q <= ST_TAIL;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          // last high phase completes before chip select is released
          if (tick_i) begin
            cs_n_o     <= 1'b1;
            gap_half_q <= 1'b0;
            state_q    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (gap_half_q) state_q <= ST_IDLE;
            else            gap_half_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dadc_bit_capture.sv
module dadc_bit_capture #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  sample_i,
  input  logic                  sdo_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)         frame_o <= '0;
    else if (sample_i) frame_o <= {frame_o[FRAME_BITS-2:0], sdo_i};
  end
endmodule

// File: rtl/dadc_field_split.sv
module dadc_field_split #(
  parameter int FRAME_BITS = 32,
  parameter int RES_W      = 12,
  parameter int GAP_BITS   = 4,
  parameter int LEAD_BITS  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    load_i,
  input  logic [FRAME_BITS-1:0]   frame_i,
  output logic                    valid_o,
  output logic signed [RES_W-1:0] ch_a_o,
  output logic signed [RES_W-1:0] ch_b_o,
  output logic                    err_o
);
  localparam int A_MSB = FRAME_BITS - 1 - LEAD_BITS;
  localparam int A_LSB = A_MSB - RES_W + 1;
  localparam int B_MSB = A_LSB - GAP_BITS - 1;
  localparam int B_LSB = B_MSB - RES_W + 1;

  logic [FRAME_BITS-1:0] zmask;

  for (genvar g = 0; g < FRAME_BITS; g++) begin : g_zmask
    if ((g >= A_LSB && g <= A_MSB) || (g >= B_LSB && g <= B_MSB)) begin : g_data
      assign zmask[g] = 1'b0;
    end else begin : g_zero
      assign zmask[g] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o <= 1'b0;
      ch_a_o  <= '0;
      ch_b_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        ch_a_o <= frame_i[A_MSB:A_LSB];
        ch_b_o <= frame_i[B_MSB:B_LSB];
        err_o  <= |(frame_i & zmask);
      end
    end
  end
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DIV_HALF   = 2,
  parameter int FRAME_BITS = 32,
  parameter int RES_W      = 12,
  parameter int GAP_BITS   = 4,
  parameter int LEAD_BITS  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    start_i,
  input  logic                    cont_i,
  input  logic                    stop_i,
  input  logic                    sdo_i,
  output logic                    sclk_o,
  output logic                    cs_n_o,
  output logic                    busy_o,
  output logic                    pair_valid_o,
  output logic signed [RES_W-1:0] ch_a_o,
  output logic signed [RES_W-1:0] ch_b_o,
  output logic                    frame_err_o
);
  logic                  run_w;
  logic                  tick_w;
  logic                  sample_w;
  logic                  done_w;
  logic [FRAME_BITS-1:0] frame_w;

  dadc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run_w),
    .tick_o(tick_w)
  );

  dadc_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .cont_i  (cont_i),
    .stop_i  (stop_i),
    .tick_i  (tick_w),
    .run_o   (run_w),
    .sample_o(sample_w),
    .done_o  (done_w),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .busy_o  (busy_o)
  );

  dadc_bit_capture #(.FRAME_BITS(FRAME_BITS)) u_cap (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sample_i(sample_w),
    .sdo_i   (sdo_i),
    .frame_o (frame_w)
  );

  dadc_field_split #(
    .FRAME_BITS(FRAME_BITS),
    .RES_W     (RES_W),
    .GAP_BITS  (GAP_BITS),
    .LEAD_BITS (LEAD_BITS)
  ) u_split (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (done_w),
    .frame_i(frame_w),
    .valid_o(pair_valid_o),
    .ch_a_o (ch_a_o),
    .ch_b_o (ch_b_o),
    .err_o  (frame_err_o)
  );
endmodule

// File: rtl/dadc_reader_chk.sv
module dadc_reader_chk #(
  parameter int FRAME_BITS = 32,
  parameter int DIV_HALF   = 2
) (
  input logic clk_i,
  input logic rst_i,
  input logic sclk_o,
  input logic cs_n_o,
  input logic pair_valid_o
);
  localparam int RCW = $clog2(FRAME_BITS);

  logic           sclk_q;
  logic [15:0]    run_len_q;
  logic [RCW-1:0] rise_cnt_q;
  logic           seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sclk_q     <= 1'b1;
      run_len_q  <= 16'(DIV_HALF);
      rise_cnt_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (sclk_o != sclk_q)        run_len_q <= 16'd1;
      else if (run_len_q != 16'hFFFF) run_len_q <= run_len_q + 16'd1;
      if (cs_n_o) begin
        rise_cnt_q <= '0;
        seen_q     <= 1'b0;
      end else if (sclk_o && !sclk_q) begin
        seen_q     <= 1'b1;
        rise_cnt_q <= (rise_cnt_q == RCW'(FRAME_BITS - 1)) ? '0 : rise_cnt_q + 1'b1;
      end
    end
  end

  p_idle_sclk_high_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_n_o |-> sclk_o);

  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    pair_valid_o |=> !pair_valid_o);

  p_release_on_boundary_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cs_n_o) |-> (seen_q && rise_cnt_q == '0));

  p_release_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cs_n_o) |=> cs_n_o);

  p_phase_min_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (sclk_o != sclk_q) |-> (run_len_q >= 16'(DIV_HALF)));
endmodule

bind dual_adc_reader dadc_reader_chk #(
  .FRAME_BITS(FRAME_BITS),
  .DIV_HALF  (DIV_HALF)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .pair_valid_o(pair_valid_o)
);

// File: tb/dual_adc_reader_tb_top.sv
module dual_adc_reader_tb_top;
  localparam int DIV = 2;

  typedef struct packed {
    logic signed [11:0] a;
    logic signed [11:0] b;
    logic               e;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cont = 1'b0, stop = 1'b0, sdo = 1'b0;
  logic sclk, cs_n, busy, pvalid, ferr;
  logic signed [11:0] cha, chb;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  exp_t        exp_q[$];
  logic [31:0] slv_q[$];

  int nvalid = 0, cs_rises = 0, last_rises = 0, rises_now = 0;
  int min_phase = 1000000, hold = 0, min_gap = 1000000, gap_len = 0;
  int dbl_valid = 0;
  logic prev_s = 1'b1, prev_cs = 1'b1, prev_v = 1'b0;
  bit released = 1'b0;

  always #5 clk = ~clk;

  dual_adc_reader #(.DIV_HALF(DIV)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .cont_i(cont), .stop_i(stop),
    .sdo_i(sdo), .sclk_o(sclk), .cs_n_o(cs_n), .busy_o(busy),
    .pair_valid_o(pvalid), .ch_a_o(cha), .ch_b_o(chb), .frame_err_o(ferr)
  );

  // slave: loads a frame word on the first fall, shifts on each falling edge
  logic [31:0] cur = '0;
  int idx = 0;
  always @(posedge cs_n) idx = 0;
  always @(negedge sclk) begin
    if (!cs_n) begin
      if (idx == 0) begin
        cur = (slv_q.size() > 0) ? slv_q.pop_front() : 32'h0;
        idx = 32;
      end
      sdo = cur[idx-1];
      idx = idx - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_pair(input logic signed [11:0] a, input logic signed [11:0] b,
                           input logic [31:0] inj);
    exp_t x;
    x.a = a; x.b = b; x.e = (inj != 0);
    exp_q.push_back(x);
    slv_q.push_back({2'b00, a, 4'b0000, b, 2'b00} | inj);
  endtask

  task automatic pulse_start(input logic c);
    @(negedge clk); start = 1'b1; cont = c;
    @(negedge clk); start = 1'b0; cont = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // monitor and scoreboard compare, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (pvalid) begin
        nvalid++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected valid", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          chk(cha == x.a, "R3 R4", "channel A", int'(cha), int'(x.a));
          chk(chb == x.b, "R3 R4", "channel B", int'(chb), int'(x.b));
          chk(ferr == x.e, "R8", "frame error flag", int'(ferr), int'(x.e));
        end
      end
      if (pvalid && prev_v) dbl_valid++;
      prev_v = pvalid;
      if (sclk != prev_s) begin
        if (!cs_n && hold < min_phase) min_phase = hold;
        if (sclk && !cs_n) rises_now++;
        hold = 1;
      end else hold++;
      prev_s = sclk;
      if (cs_n && !prev_cs) begin
        cs_rises++; last_rises = rises_now; rises_now = 0;
        released = 1'b1; gap_len = 0;
      end
      if (cs_n) gap_len++;
      if (!cs_n && prev_cs) begin
        if (released && gap_len < min_gap) min_gap = gap_len;
        rises_now = 0;
      end
      prev_cs = cs_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, rbase;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b1, "R1", "sclk after reset", int'(sclk), 1);
    chk(pvalid == 1'b0 && busy == 1'b0, "R1", "valid/busy after reset",
        int'(pvalid | busy), 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);

    // single shot, asymmetric pattern (R2 R3 R4)
    rbase = cs_rises; base = nvalid;
    push_pair(12'sh123, -12'sd1093, 32'h0);
    pulse_start(1'b0);
    wait_idle();
    chk(last_rises == 32, "R2", "rising edges per frame", last_rises, 32);
    chk(nvalid - base == 1, "R5", "pairs in single shot", nvalid - base, 1);

    // R10: extra start pulses while busy, with continuous asked, are ignored
    base = nvalid; rbase = cs_rises;
    push_pair(12'sd2047, -12'sd2048, 32'h0);
    pulse_start(1'b0);
    repeat (30) @(negedge clk);
    pulse_start(1'b1);
    repeat (40) @(negedge clk);
    pulse_start(1'b1);
    wait_idle();
    repeat (50) @(negedge clk);
    chk(nvalid - base == 1, "R10", "frames after busy starts", nvalid - base, 1);
    chk(cs_rises - rbase == 1, "R10", "releases after busy starts", cs_rises - rbase, 1);

    // R6 R7: continuous, stop in the middle of the fourth frame
    base = nvalid; rbase = cs_rises;
    push_pair(-12'sd2048, 12'sd2047, 32'h0);
    push_pair(12'sd0, -12'sd1, 32'h0);
    push_pair(12'sd1, -12'sd2, 32'h0);
    push_pair(12'sh555, -12'sd1366, 32'h0);
    push_pair(12'sd7, 12'sd7, 32'h0); // must never be read
    pulse_start(1'b1);
    wait (nvalid == base + 3);
    repeat (20) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    wait_idle();
    repeat (200) @(negedge clk);
    chk(nvalid - base == 4, "R7", "frames before stop", nvalid - base, 4);
    chk(cs_rises - rbase == 1, "R6", "releases in continuous run", cs_rises - rbase, 1);
    chk(last_rises == 128, "R6", "rising edges under one select", last_rises, 128);
    void'(exp_q.pop_back());
    slv_q.delete();

    // R8: ones in the gap field and in a lead bit
    push_pair(12'sd100, -12'sd100, 32'h0000_8000);
    pulse_start(1'b0);
    wait_idle();
    push_pair(-12'sd300, 12'sd301, 32'h8000_0000);
    pulse_start(1'b0);
    wait_idle();
    push_pair(12'sd5, 12'sd6, 32'h0000_0001);
    pulse_start(1'b0);
    wait_idle();

    // R7: start held high, new start only after release gap
    base = nvalid;
    push_pair(12'sh801, 12'sh7FE, 32'h0);
    push_pair(-12'sd5, 12'sd5, 32'h0);
    @(negedge clk); start = 1'b1; cont = 1'b0;
    wait (nvalid == base + 2);
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk(min_gap >= 2 * DIV, "R7", "release gap cycles", min_gap, 2 * DIV);

    repeat (20) @(negedge clk);
    chk(min_phase == DIV, "R9", "shortest sclk phase", min_phase, DIV);
    chk(dbl_valid == 0, "R5", "valid wider than one cycle", dbl_valid, 0);
    chk(exp_q.size() == 0, "R5", "pairs left in scoreboard", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule